// File: doc/BRIEF.md
# Timer Compare-Output Unit

This block is an 8-bit timer counter with one compare channel. It advances on a single-cycle timer enable. Software reaches it through a small register write port, which has four addresses: the counter, the compare value, a control byte and a flag-clear strobe. The counter has three counting modes:

- a free-running up count that wraps;
- an up count that returns to zero after it equals the compare value;
- a triangle count that runs up to the all-ones value and back down to zero.

Each unblocked compare match sets a sticky flag and acts on an internal output bit. The control byte selects that action: toggle, clear, set or none. In the triangle mode the action depends on the count direction. A force strobe applies the same action with no match. It sets no flag and leaves the counter untouched.

The compare value can be held in a buffer so that the triangle waveform only changes at its top. The output-action field is not buffered. A new action applies from the next timer tick on. A write to the counter arms a one-shot block, and this block drops the compare match on the next timer tick, however long that tick takes to arrive. When the output-action field is nonzero, the output bit replaces the general port data on a pin. The pin's direction input still decides whether anything drives the pin.

Top module: `tcu_top`

## Requirements
- R1: After reset the counter, the active compare value, the match flag, the output bit, `pin_out` and `pin_oe` are all 0, and the counting mode is the wrapping up count.
- R2: In the wrapping mode (control bits [1:0] = 00, and also for the unused code 11), every cycle with `tick` high adds one to the counter, wrapping from 255 to 0. With no `tick` and no counter write, the count holds.
- R3: When `tick` is high, no block is armed, and the counter equals the active compare value, `match_flag` reads 1 from the next cycle on. Writing a value with bit 0 set to address 3 clears the flag. If a match and a clear fall in the same cycle, the match wins.
- R4: In the clear-on-match mode (control bits [1:0] = 01), the tick that produces an unblocked match loads 0 into the counter. On a blocked or non-matching tick the counter counts up.
- R5: In the two non-triangle modes, control bits [3:2] select what a match does to the output bit: 00 leaves it alone, 01 toggles it, 10 clears it and 11 sets it. A new value of this field applies from the cycle after its control write.
- R6: Writing control bit 5 as 1 while the new counting mode is not the triangle mode applies the action of the bits [3:2] being written to the output bit. This forced action does not set the flag and does not change the counter. If the new counting mode is the triangle mode, the strobe has no effect on the output bit.
- R7: A write to address 0 loads the counter and arms a block. The next tick clears the block and produces no match, even if cycles without a tick pass in between. A tick in the same cycle as a counter write is dropped.
- R8: With control bit 4 set in the triangle mode, a write to address 1 goes only to the buffer. The buffer is copied into the active compare value on the tick where the counter is 255 and counting up. In every other case a write to address 1 updates the active value at once.
- R9: In the triangle mode (control bits [1:0] = 10), the counter counts up to 255, then down to 0, then up again. A match while counting up applies action 10 as clear and 11 as set. A match while counting down applies 10 as set and 11 as clear. Action 01 toggles in both directions.
- R10: `pin_oe` equals `gpio_dir`. When `gpio_dir` is 0, `pin_out` is 0. Otherwise `pin_out` is the output bit if control bits [3:2] are nonzero, and `gpio_out` if they are zero.
- R11: The output bit keeps its value when the counting mode changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable, one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 counter, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| gpio_out | input | 1 | General port data for the pin |
| gpio_dir | input | 1 | Pin direction, 1 = drive |
| count | output | 8 | Current counter value |
| cmp_value | output | 8 | Active compare value |
| match_flag | output | 1 | Sticky compare match flag |
| oc_bit | output | 1 | Internal compare output bit |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The counting function is driven from a table of start values and tick counts:

- a short run with no wrap;
- runs that cross the 255-to-0 wrap;
- a single tick from the all-ones value;
- a run of zero ticks, which shows that the count holds without `tick`.

Matches are then made to occur:

- right after a counter write of the compare value, so a blocked match can be told apart from a real one;
- after idle cycles with no tick, which shows that the block waits for a tick and does not time out;
- one count later, which shows that the block lasts for only one tick.

Each action code is tried both through a match and through the force strobe, so an action fault can be told apart from a fault in the match path. A full triangle period with a buffered compare write shows:

- the top-only update of the active value;
- the action flipping with the count direction.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  typedef enum logic [1:0] {
    WV_WRAP   = 2'b00,
    WV_CLEAR  = 2'b01,
    WV_TRI    = 2'b10,
    WV_UNUSED = 2'b11
  } wave_e;

  typedef enum logic [1:0] {
    OM_NONE   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } omode_e;

  localparam logic [1:0] ADDR_COUNT = 2'd0;
  localparam logic [1:0] ADDR_CMP   = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_FLAG  = 2'd3;

  localparam int CTRL_BUF_BIT   = 4;
  localparam int CTRL_FORCE_BIT = 5;

  function automatic logic is_tri(input logic [1:0] wave);
    return wave == WV_TRI;
  endfunction

  // Action of a match or force in the non-triangle modes
  function automatic logic act_flat(input logic [1:0] om, input logic cur);
    case (om)
      OM_TOGGLE: return ~cur;
      OM_CLEAR:  return 1'b0;
      OM_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

  // Action of a match in the triangle mode, flipped while counting down
  function automatic logic act_tri(input logic [1:0] om, input logic cur,
                                   input logic down);
    case (om)
      OM_TOGGLE: return ~cur;
      OM_CLEAR:  return down;
      OM_SET:    return ~down;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/tcu_regs.sv
module tcu_regs
  import tcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         top_upd,
  output logic [1:0]   wave,
  output logic [1:0]   omode,
  output logic [W-1:0] cmp_active,
  output logic         cnt_wr,
  output logic         flag_clr,
  output logic         force_evt,
  output logic [1:0]   force_mode
);

  logic         buf_en;
  logic [W-1:0] cmp_buf;
  logic         ctrl_wr;
  logic         cmp_wr;
  logic         buffered;

  assign cnt_wr     = wr_en && (wr_addr == ADDR_COUNT);
  assign cmp_wr     = wr_en && (wr_addr == ADDR_CMP);
  assign ctrl_wr    = wr_en && (wr_addr == ADDR_CTRL);
  assign flag_clr   = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];
  assign buffered   = buf_en && is_tri(wave);
  assign force_evt  = ctrl_wr && wr_data[CTRL_FORCE_BIT] && !is_tri(wr_data[1:0]);
  assign force_mode = wr_data[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave   <= WV_WRAP;
      omode  <= OM_NONE;
      buf_en <= 1'b0;
    end else if (ctrl_wr) begin
      wave   <= wr_data[1:0];
      omode  <= wr_data[3:2];
      buf_en <= wr_data[CTRL_BUF_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf    <= '0;
      cmp_active <= '0;
    end else begin
      if (cmp_wr) cmp_buf <= wr_data;
      if (cmp_wr && !buffered)             cmp_active <= wr_data;
      else if (top_upd && is_tri(wave))    cmp_active <= cmp_buf;
    end
  end

  // R8: a buffered write leaves the active value alone until the top
  a_r8_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !ctrl_wr && !top_upd) |=> $stable(cmp_active));

endmodule

// File: rtl/tcu_counter.sv
module tcu_counter
  import tcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   wave,
  input  logic [W-1:0] cmp_active,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] count,
  output logic         match_evt,
  output logic         top_upd,
  output logic         cnt_down
);

  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         blk_pend;
  logic         step;
  logic         cmp_eq;
  logic [W-1:0] cnt_nxt;
  logic         down_nxt;

  assign step      = tick && !cnt_wr;
  assign cmp_eq    = (count == cmp_active);
  assign match_evt = step && cmp_eq && !blk_pend;
  assign top_upd   = step && is_tri(wave) && !cnt_down && (count == TOP);

  always_comb begin
    cnt_nxt  = count + ONE;
    down_nxt = 1'b0;
    case (wave)
      WV_CLEAR: if (match_evt) cnt_nxt = '0;
      WV_TRI: begin
        down_nxt = cnt_down;
        if (!cnt_down) begin
          if (count == TOP) begin
            cnt_nxt  = TOP - ONE;
            down_nxt = 1'b1;
          end
        end else if (count == '0) begin
          cnt_nxt  = ONE;
          down_nxt = 1'b0;
        end else begin
          cnt_nxt = count - ONE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      cnt_down <= 1'b0;
      blk_pend <= 1'b0;
    end else if (cnt_wr) begin
      count    <= cnt_wdata;
      blk_pend <= 1'b1;
    end else if (step) begin
      count    <= cnt_nxt;
      cnt_down <= down_nxt;
      blk_pend <= 1'b0;
    end
  end

  // R7: the armed block swallows the next tick's match
  a_r7_block_next_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blk_pend) |-> !match_evt);
  a_r7_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (blk_pend && count == $past(cnt_wdata)));
  // R2: the count holds without a tick or a write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));
  // R4: clear-on-match mode returns to zero after a match
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && wave == WV_CLEAR) |=> (count == '0));

endmodule

// File: rtl/tcu_output.sv
module tcu_output
  import tcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_evt,
  input  logic       cnt_down,
  input  logic [1:0] wave,
  input  logic [1:0] omode,
  input  logic       force_evt,
  input  logic [1:0] force_mode,
  input  logic       flag_clr,
  input  logic       gpio_out,
  input  logic       gpio_dir,
  output logic       oc_bit,
  output logic       flag,
  output logic       pin_out,
  output logic       pin_oe
);

  logic oc_nxt;

  always_comb begin
    oc_nxt = oc_bit;
    if (match_evt)
      oc_nxt = is_tri(wave) ? act_tri(omode, oc_bit, cnt_down)
                            : act_flat(omode, oc_bit);
    else if (force_evt)
      oc_nxt = act_flat(force_mode, oc_bit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_bit <= 1'b0;
      flag   <= 1'b0;
    end else begin
      oc_bit <= oc_nxt;
      if (match_evt)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assign pin_oe  = gpio_dir;
  assign pin_out = gpio_dir && ((omode != OM_NONE) ? oc_bit : gpio_out);

  // R3: a match always leaves the flag set
  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag);
  // R6: a forced action never raises the flag
  a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !match_evt && !flag) |=> !flag);
  // R10: an input-direction pin is never driven high
  a_r10_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_dir |-> (!pin_out && !pin_oe));
  // R11: no event, no change of the output bit
  a_r11_oc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt && !force_evt) |=> $stable(oc_bit));

endmodule

// File: rtl/tcu_top.sv
module tcu_top
  import tcu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         gpio_out,
  input  logic         gpio_dir,
  output logic [W-1:0] count,
  output logic [W-1:0] cmp_value,
  output logic         match_flag,
  output logic         oc_bit,
  output logic         pin_out,
  output logic         pin_oe
);

  logic [1:0] wave;
  logic [1:0] omode;
  logic       cnt_wr;
  logic       flag_clr;
  logic       force_evt;
  logic [1:0] force_mode;
  logic       match_evt;
  logic       top_upd;
  logic       cnt_down;

  tcu_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .top_upd    (top_upd),
    .wave       (wave),
    .omode      (omode),
    .cmp_active (cmp_value),
    .cnt_wr     (cnt_wr),
    .flag_clr   (flag_clr),
    .force_evt  (force_evt),
    .force_mode (force_mode)
  );

  tcu_counter #(.W(W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wave       (wave),
    .cmp_active (cmp_value),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (wr_data),
    .count      (count),
    .match_evt  (match_evt),
    .top_upd    (top_upd),
    .cnt_down   (cnt_down)
  );

  tcu_output u_output (
    .clk        (clk),
    .rst_n      (rst_n),
    .match_evt  (match_evt),
    .cnt_down   (cnt_down),
    .wave       (wave),
    .omode      (omode),
    .force_evt  (force_evt),
    .force_mode (force_mode),
    .flag_clr   (flag_clr),
    .gpio_out   (gpio_out),
    .gpio_dir   (gpio_dir),
    .oc_bit     (oc_bit),
    .flag       (match_flag),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  // R9: the triangle top update fires only while counting up
  a_r9_top_up_only: assert property (@(posedge clk) disable iff (!rst_n)
    top_upd |-> (!cnt_down && count == {W{1'b1}}));

endmodule

// File: tb/tcu_top_test.sv
module tcu_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       gpio_out = 1'b0;
  logic       gpio_dir = 1'b0;
  logic [7:0] count;
  logic [7:0] cmp_value;
  logic       match_flag;
  logic       oc_bit;
  logic       pin_out;
  logic       pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcu_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gpio_out(gpio_out), .gpio_dir(gpio_dir),
    .count(count), .cmp_value(cmp_value), .match_flag(match_flag),
    .oc_bit(oc_bit), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {start value, ticks, expected count} for the wrapping mode
  localparam logic [23:0] VEC [6] = '{
    {8'd10,  8'd5,   8'd15},
    {8'd250, 8'd10,  8'd4},
    {8'd255, 8'd1,   8'd0},
    {8'd77,  8'd0,   8'd77},
    {8'd128, 8'd127, 8'd255},
    {8'd200, 8'd56,  8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 cmp", cmp_value, 0);
    chk("R1 flag", match_flag, 0);
    chk("R1 oc", oc_bit, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);

    // R10 pin source selection
    gpio_out = 1'b1;
    @(negedge clk);
    chk("R10 dir0 pin_out", pin_out, 0);
    gpio_dir = 1'b1;
    @(negedge clk);
    chk("R10 port data", pin_out, 1);
    chk("R10 pin_oe", pin_oe, 1);
    wr(2'd2, 8'h0C);
    chk("R10 override by oc", pin_out, 0);
    wr(2'd2, 8'h00);

    // R2 table walk
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VEC[i][23:16]);
      run(int'(VEC[i][15:8]));
      repeat (2) @(negedge clk);
      chk("R2 count", count, int'(VEC[i][7:0]));
    end

    // R3 match and flag clear
    wr(2'd1, 8'd20);
    wr(2'd3, 8'h01);
    chk("R3 flag cleared", match_flag, 0);
    wr(2'd0, 8'd18);
    run(3);
    chk("R3 flag set", match_flag, 1);
    chk("R3 count after", count, 21);
    wr(2'd3, 8'h01);
    chk("R3 clear", match_flag, 0);

    // R7 block after counter write
    wr(2'd0, 8'd20);
    run(1);
    chk("R7 blocked", match_flag, 0);
    chk("R7 count", count, 21);
    wr(2'd0, 8'd20);
    repeat (5) @(negedge clk);
    run(1);
    chk("R7 blocked while stopped", match_flag, 0);
    wr(2'd0, 8'd19);
    run(2);
    chk("R7 one tick only", match_flag, 1);
    wr(2'd3, 8'h01);

    // R5 match actions
    wr(2'd2, 8'h0C);
    wr(2'd0, 8'd19); run(2);
    chk("R5 set", oc_bit, 1);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd19); run(2);
    chk("R5 none", oc_bit, 1);
    wr(2'd2, 8'h08);
    wr(2'd0, 8'd19); run(2);
    chk("R5 clear", oc_bit, 0);
    wr(2'd2, 8'h04);
    wr(2'd0, 8'd19); run(2);
    chk("R5 toggle 1", oc_bit, 1);
    wr(2'd0, 8'd19); run(2);
    chk("R5 toggle 2", oc_bit, 0);

    // R6 force strobe
    wr(2'd3, 8'h01);
    saved = count;
    wr(2'd2, 8'h2C);
    chk("R6 force set", oc_bit, 1);
    chk("R6 no flag", match_flag, 0);
    chk("R6 count kept", count, int'(saved));
    wr(2'd2, 8'h28);
    chk("R6 force clear", oc_bit, 0);
    wr(2'd2, 8'h2E);
    chk("R6 ignored in triangle", oc_bit, 0);

    // R11 output bit kept across mode changes
    wr(2'd2, 8'h2C);
    wr(2'd2, 8'h0D);
    chk("R11 kept clear-mode", oc_bit, 1);
    wr(2'd2, 8'h02);
    chk("R11 kept triangle", oc_bit, 1);

    // R4 clear-on-match
    wr(2'd2, 8'h01);
    wr(2'd1, 8'd5);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'd0);
    run(6);
    chk("R4 zero", count, 0);
    chk("R4 flag", match_flag, 1);
    run(1);
    chk("R4 restart", count, 1);

    // R8 immediate write when not in triangle mode
    wr(2'd2, 8'h10);
    wr(2'd1, 8'd77);
    chk("R8 immediate", cmp_value, 77);

    // R8 / R9 triangle with buffered compare
    wr(2'd1, 8'd100);
    wr(2'd2, 8'h2C);
    wr(2'd2, 8'h1A);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd50);
    chk("R8 buffered held", cmp_value, 100);
    run(101);
    chk("R9 up count", count, 101);
    chk("R9 up match clears", oc_bit, 0);
    chk("R8 held before top", cmp_value, 100);
    run(155);
    chk("R9 turn at top", count, 254);
    chk("R8 loaded at top", cmp_value, 50);
    run(205);
    chk("R9 down count", count, 49);
    chk("R9 down match sets", oc_bit, 1);
    run(50);
    chk("R9 turn at bottom", count, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule